// File: doc/BRIEF.md
# Page-Mode Nonvolatile Memory Bus Controller

This block sits between a synchronous host and a 16-bit parallel nonvolatile memory with SRAM-style pins. The memory holds 256K words and has asynchronous strobes: a chip enable, an output enable, a write enable, and two active-low byte-lane selects. The host places one word request at a time on a request/ready handshake. The controller turns each request into a strobe sequence that meets the memory's timing minimums. Every minimum is a parameter in nanoseconds, and the controller rounds it up to whole cycles of a configurable clock period.

Chip enable must stay low for a minimum active time and then high for a precharge interval before it can fall again. The host can get a faster page access by issuing its next request in the same cycle the controller signals completion, provided the new address shares bits 17..2 with the current one. Chip enable then stays low and only the two low address bits move. A request for a different page, or a cycle with no request, closes the page and starts a precharge.

The controller drives the data bus only while write enable is low, and it keeps output enable high during that time. On reads the bus stays released so that the memory can drive it.

Top module: `fram_page_ctrl`

## Requirements
- R1: During and right after reset, mem_ce_n, mem_oe_n, mem_we_n, mem_ub_n and mem_lb_n are 1, and mem_dq_oe and ack are 0.
- R2: Each time mem_ce_n falls, it stays low for at least N_FIRST cycles. N_FIRST is the largest of the rounded active time, chip-enable access time, output-enable access time and address hold time, which is 3 cycles at 20 ns.
- R3: Between two low periods, mem_ce_n stays high for at least N_PC cycles (3 at 20 ns) of precharge.
- R4: mem_addr and the byte-lane selects take their new values at least one cycle before mem_ce_n falls, and they are unchanged at the fall.
- R5: When a request arrives with chip enable released and precharge done, ack rises 2+N_FIRST cycles (5) after the request is presented. On a read, rdata in the ack cycle equals the word last stored at that address, or 0 if the address was never written.
- R6: For a page read, the controller moves only mem_addr[1:0] while mem_ce_n stays low. The page read acks 1+N_PRD cycles (3) after the request, and returns the stored word.
- R7: mem_dq_oe is 1 only while mem_we_n is 0, and mem_oe_n is 1 throughout that time.
- R8: req_be[1] selects the upper byte (mem_ub_n low) and req_be[0] the lower byte (mem_lb_n low). A write changes only the enabled bytes of the stored word.
- R9: When a request for a different page arrives in the ack cycle, chip enable is released and a full precharge runs. The access then acks N_PC+2+N_FIRST cycles (8) after the request.
- R10: For a page write, the new address is presented N_WSU cycles (1) before mem_we_n falls, and mem_we_n stays low for N_WLO cycles (1). The page write acks 1+N_WSU+N_WLO cycles (3) after the request.
- R11: ack is high for exactly one cycle per accepted request, never on two consecutive cycles.
- R12: If no request is present in the ack cycle, mem_ce_n is 1 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Host request, held until ack |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address |
| req_be | input | 2 | Byte enables, bit 1 upper, bit 0 lower |
| req_wdata | input | 16 | Write data |
| ack | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Read data, valid with ack |
| mem_addr | output | 18 | Memory address |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_ub_n | output | 1 | Upper byte select, active low |
| mem_lb_n | output | 1 | Lower byte select, active low |
| mem_dq_out | output | 16 | Data driven toward memory |
| mem_dq_oe | output | 1 | Data bus drive enable |
| mem_dq_in | input | 16 | Data read from memory |

## Verification
The stimulus mixes four kinds of request:
- Cold requests issued after an idle gap, which show the random-access latency.
- Back-to-back requests inside one four-word page, which separate page reads from page writes by their latency.
- Back-to-back requests that leave the page, which show whether precharge really closes the page.
- Partial byte-enable writes followed by reads, which expose any lane swap or any write to a disabled lane.

Read data is compared against a word-level model with byte masking. Latency is compared against the cycle counts derived from the nanosecond parameters. The strobe run lengths and the bus drive window are watched in every cycle.

// File: rtl/fram_pkg.sv
`timescale 1ns/1ps
package fram_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_FIRST,
    ST_OPEN,
    ST_WSU,
    ST_WLOW,
    ST_PRD
  } fram_st_t;

  function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned per_ns);
    return (ns + per_ns - 1) / per_ns;
  endfunction

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/fram_timer.sv
`timescale 1ns/1ps
module fram_timer #(
  parameter int W       = 4,
  parameter int RST_VAL = 0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)               cnt <= W'(RST_VAL);
    else if (load)         cnt <= load_val;
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/fram_page_match.sv
`timescale 1ns/1ps
module fram_page_match #(
  parameter int UW = 16
) (
  input  logic [UW-1:0] cur_page,
  input  logic [UW-1:0] nxt_page,
  output logic          same
);
  assign same = (cur_page == nxt_page);
endmodule

// File: rtl/fram_page_ctrl.sv
`timescale 1ns/1ps
module fram_page_ctrl
  import fram_pkg::*;
#(
  parameter int AW         = 18,
  parameter int DW         = 16,
  parameter int PAGE_W     = 2,
  parameter int CLK_NS     = 20,
  parameter int T_CA_NS    = 55,
  parameter int T_CE_NS    = 55,
  parameter int T_OE_NS    = 15,
  parameter int T_AH_NS    = 55,
  parameter int T_PC_NS    = 55,
  parameter int T_PAGE_NS  = 25,
  parameter int T_WP_NS    = 16,
  parameter int T_ASP_NS   = 8,
  parameter int T_AHP_NS   = 15,
  parameter int T_PWC_NS   = 25
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req,
  input  logic          req_we,
  input  logic [AW-1:0] req_addr,
  input  logic [1:0]    req_be,
  input  logic [DW-1:0] req_wdata,
  output logic          ack,
  output logic [DW-1:0] rdata,
  output logic [AW-1:0] mem_addr,
  output logic          mem_ce_n,
  output logic          mem_oe_n,
  output logic          mem_we_n,
  output logic          mem_ub_n,
  output logic          mem_lb_n,
  output logic [DW-1:0] mem_dq_out,
  output logic          mem_dq_oe,
  input  logic [DW-1:0] mem_dq_in
);
  localparam int unsigned N_FIRST = umax(umax(ns_to_cyc(T_CA_NS, CLK_NS), ns_to_cyc(T_CE_NS, CLK_NS)),
                                         umax(umax(ns_to_cyc(T_OE_NS, CLK_NS), ns_to_cyc(T_AH_NS, CLK_NS)), 1));
  localparam int unsigned N_PC    = umax(ns_to_cyc(T_PC_NS, CLK_NS), 1);
  localparam int unsigned N_PRD   = umax(ns_to_cyc(T_PAGE_NS, CLK_NS), 1);
  localparam int unsigned N_WSU   = umax(ns_to_cyc(T_ASP_NS, CLK_NS), 1);
  localparam int unsigned N_PWC   = ns_to_cyc(T_PWC_NS, CLK_NS);
  localparam int unsigned N_WREST = (N_PWC > N_WSU) ? (N_PWC - N_WSU) : 1;
  localparam int unsigned N_WLO   = umax(umax(ns_to_cyc(T_WP_NS, CLK_NS), ns_to_cyc(T_AHP_NS, CLK_NS)), N_WREST);
  localparam int unsigned N_BIG   = umax(umax(N_FIRST, N_PC), umax(umax(N_PRD, N_WSU), N_WLO));
  localparam int          TW      = $clog2(N_BIG + 1) + 1;
  localparam int          UW      = AW - PAGE_W;

  fram_st_t      state;
  logic          wr_q;
  logic          acc_load, acc_exp, pc_load, pc_exp, same_pg;
  logic [TW-1:0] acc_val;
  logic          accept, cont;

  fram_page_match #(.UW(UW)) u_match (
    .cur_page (mem_addr[AW-1:PAGE_W]),
    .nxt_page (req_addr[AW-1:PAGE_W]),
    .same     (same_pg)
  );

  fram_timer #(.W(TW), .RST_VAL(0)) u_acc (
    .clk(clk), .rst(rst), .load(acc_load), .load_val(acc_val), .expired(acc_exp)
  );

  fram_timer #(.W(TW), .RST_VAL(N_PC - 1)) u_pc (
    .clk(clk), .rst(rst), .load(pc_load), .load_val(TW'(N_PC - 1)), .expired(pc_exp)
  );

  always_comb begin
    accept   = (state == ST_IDLE) && req && pc_exp;
    cont     = (state == ST_OPEN) && req && same_pg;
    pc_load  = (state == ST_OPEN) && !cont;
    acc_load = 1'b0;
    acc_val  = '0;
    if (state == ST_START) begin
      acc_load = 1'b1;
      acc_val  = TW'(N_FIRST - 1);
    end else if (cont) begin
      acc_load = 1'b1;
      acc_val  = req_we ? TW'(N_WSU - 1) : TW'(N_PRD - 1);
    end else if ((state == ST_WSU) && acc_exp) begin
      acc_load = 1'b1;
      acc_val  = TW'(N_WLO - 1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      wr_q       <= 1'b0;
      ack        <= 1'b0;
      rdata      <= '0;
      mem_addr   <= '0;
      mem_ce_n   <= 1'b1;
      mem_oe_n   <= 1'b1;
      mem_we_n   <= 1'b1;
      mem_ub_n   <= 1'b1;
      mem_lb_n   <= 1'b1;
      mem_dq_out <= '0;
      mem_dq_oe  <= 1'b0;
    end else begin
      ack <= 1'b0;
      case (state)
        ST_IDLE: if (accept) begin
          mem_addr   <= req_addr;
          mem_ub_n   <= ~req_be[1];
          mem_lb_n   <= ~req_be[0];
          mem_dq_out <= req_wdata;
          wr_q       <= req_we;
          state      <= ST_START;
        end
        ST_START: begin
          mem_ce_n <= 1'b0;
          if (wr_q) begin
            mem_we_n  <= 1'b0;
            mem_dq_oe <= 1'b1;
          end else begin
            mem_oe_n  <= 1'b0;
          end
          state <= ST_FIRST;
        end
        ST_FIRST, ST_PRD, ST_WLOW: if (acc_exp) begin
          ack <= 1'b1;
          if (!wr_q) rdata <= mem_dq_in;
          mem_we_n  <= 1'b1;
          mem_dq_oe <= 1'b0;
          mem_oe_n  <= 1'b1;
          state     <= ST_OPEN;
        end
        ST_OPEN: begin
          if (cont) begin
            mem_addr   <= req_addr;
            mem_ub_n   <= ~req_be[1];
            mem_lb_n   <= ~req_be[0];
            mem_dq_out <= req_wdata;
            wr_q       <= req_we;
            if (req_we) begin
              state <= ST_WSU;
            end else begin
              mem_oe_n <= 1'b0;
              state    <= ST_PRD;
            end
          end else begin
            mem_ce_n <= 1'b1;
            mem_ub_n <= 1'b1;
            mem_lb_n <= 1'b1;
            state    <= ST_IDLE;
          end
        end
        ST_WSU: if (acc_exp) begin
          mem_we_n  <= 1'b0;
          mem_dq_oe <= 1'b1;
          state     <= ST_WLOW;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/fram_page_ctrl_chk.sv
`timescale 1ns/1ps
module fram_page_ctrl_chk
  import fram_pkg::*;
#(
  parameter int AW      = 18,
  parameter int PW      = 2,
  parameter int CLK_NS  = 20,
  parameter int T_CA_NS = 55,
  parameter int T_PC_NS = 55
) (
  input logic          clk,
  input logic          rst,
  input logic          ack,
  input logic [AW-1:0] mem_addr,
  input logic          mem_ce_n,
  input logic          mem_oe_n,
  input logic          mem_we_n,
  input logic          mem_ub_n,
  input logic          mem_lb_n,
  input logic          mem_dq_oe
);
  localparam int unsigned C_CA = ns_to_cyc(T_CA_NS, CLK_NS);
  localparam int unsigned C_PC = ns_to_cyc(T_PC_NS, CLK_NS);

  logic [7:0] low_cnt, high_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      low_cnt  <= '0;
      high_cnt <= '0;
    end else begin
      low_cnt  <= mem_ce_n ? 8'd0 : ((low_cnt == 8'hFF) ? low_cnt : low_cnt + 8'd1);
      high_cnt <= !mem_ce_n ? 8'd0 : ((high_cnt == 8'hFF) ? high_cnt : high_cnt + 8'd1);
    end
  end

  a_r2_ce_low_min: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_ce_n) |-> (low_cnt >= 8'(C_CA)));

  a_r3_precharge_min: assert property (@(posedge clk) disable iff (rst)
    $fell(mem_ce_n) |-> (high_cnt >= 8'(C_PC)));

  a_r4_setup_before_ce: assert property (@(posedge clk) disable iff (rst)
    $fell(mem_ce_n) |-> ($stable(mem_addr) && $stable({mem_ub_n, mem_lb_n})));

  a_r6_page_upper_fixed: assert property (@(posedge clk) disable iff (rst)
    (!mem_ce_n && $past(!mem_ce_n)) |-> (mem_addr[AW-1:PW] == $past(mem_addr[AW-1:PW])));

  a_r7_drive_only_we_low: assert property (@(posedge clk) disable iff (rst)
    mem_dq_oe |-> (!mem_we_n && mem_oe_n));

  a_r10_addr_before_we: assert property (@(posedge clk) disable iff (rst)
    ($fell(mem_we_n) && !$fell(mem_ce_n)) |-> $stable(mem_addr));

  a_r11_ack_single: assert property (@(posedge clk) disable iff (rst)
    ack |=> !ack);
endmodule

bind fram_page_ctrl fram_page_ctrl_chk #(
  .AW(AW), .PW(PAGE_W), .CLK_NS(CLK_NS), .T_CA_NS(T_CA_NS), .T_PC_NS(T_PC_NS)
) u_chk (
  .clk(clk), .rst(rst), .ack(ack), .mem_addr(mem_addr), .mem_ce_n(mem_ce_n),
  .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_ub_n(mem_ub_n),
  .mem_lb_n(mem_lb_n), .mem_dq_oe(mem_dq_oe)
);

// File: tb/sim_fram_page_ctrl.sv
`timescale 1ns/1ps
module sim_fram_page_ctrl;
  localparam int AW = 18, DW = 16, PW = 2, CLK_NS = 20;

  function automatic int cdiv(input int ns);
    return (ns + CLK_NS - 1) / CLK_NS;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int N_FIRST = mx(mx(cdiv(55), cdiv(15)), 1);
  localparam int N_PC    = mx(cdiv(55), 1);
  localparam int N_PRD   = mx(cdiv(25), 1);
  localparam int N_WSU   = mx(cdiv(8), 1);
  localparam int N_WLO   = mx(mx(cdiv(16), cdiv(15)), mx(cdiv(25) - N_WSU, 1));

  logic          clk, rst, req, req_we, ack;
  logic [AW-1:0] req_addr, mem_addr;
  logic [1:0]    req_be;
  logic [DW-1:0] req_wdata, rdata, mem_dq_out, mem_dq_in;
  logic          mem_ce_n, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n, mem_dq_oe;

  fram_page_ctrl u0 (
    .clk(clk), .rst(rst), .req(req), .req_we(req_we), .req_addr(req_addr),
    .req_be(req_be), .req_wdata(req_wdata), .ack(ack), .rdata(rdata),
    .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
    .mem_we_n(mem_we_n), .mem_ub_n(mem_ub_n), .mem_lb_n(mem_lb_n),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  initial clk = 1'b0;
  always #(CLK_NS / 2) clk = ~clk;

  int n_chk = 0, n_fail = 0, n_ops = 0, n_acks = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", rq, act, exp, $time);
    end
  endtask

  // memory model
  logic [DW-1:0] store [logic [AW-1:0]];
  function automatic logic [DW-1:0] peek(input logic [AW-1:0] a);
    if (store.exists(a)) return store[a];
    return '0;
  endfunction
  assign mem_dq_in = (!mem_ce_n && !mem_oe_n) ? peek(mem_addr) : '0;
  always @(posedge mem_we_n) begin
    if (mem_ce_n == 1'b0) begin
      logic [DW-1:0] w;
      w = peek(mem_addr);
      if (!mem_ub_n) w[15:8] = mem_dq_out[15:8];
      if (!mem_lb_n) w[7:0]  = mem_dq_out[7:0];
      store[mem_addr] = w;
    end
  end

  // reference contents
  logic [DW-1:0] refm [logic [AW-1:0]];
  function automatic logic [DW-1:0] ref_rd(input logic [AW-1:0] a);
    if (refm.exists(a)) return refm[a];
    return '0;
  endfunction
  function automatic logic [DW-1:0] merge(input logic [DW-1:0] o, input logic [1:0] be,
                                          input logic [DW-1:0] d);
    logic [DW-1:0] r;
    r = o;
    if (be[1]) r[15:8] = d[15:8];
    if (be[0]) r[7:0]  = d[7:0];
    return r;
  endfunction

  // strobe monitor
  logic prev_ce = 1'b1;
  logic [AW-1:0] prev_addr;
  logic [1:0] prev_bl;
  int low_run = 0, high_run = 0;
  always @(negedge clk) begin
    if (!rst) begin
      if (ack) n_acks++;
      if (mem_ce_n != prev_ce) begin
        if (mem_ce_n) chk(low_run >= N_FIRST, "R2 ce low run", low_run, N_FIRST);
        else begin
          chk(high_run >= N_PC, "R3 precharge run", high_run, N_PC);
          chk(mem_addr == prev_addr && {mem_ub_n, mem_lb_n} == prev_bl,
              "R4 setup before ce", int'(mem_addr), int'(prev_addr));
        end
        low_run = 0; high_run = 0;
      end
      if (mem_ce_n) high_run++; else low_run++;
      if (mem_dq_oe) chk(!mem_we_n && mem_oe_n, "R7 bus drive window",
                         {mem_we_n, mem_oe_n}, 2'b01);
      prev_ce = mem_ce_n; prev_addr = mem_addr; prev_bl = {mem_ub_n, mem_lb_n};
    end
  end

  bit open_flag = 0;
  logic [AW-PW-1:0] open_pg;

  task automatic op(input bit we, input logic [AW-1:0] a, input logic [1:0] be,
                    input logic [DW-1:0] d);
    int lat, exp_lat;
    string tag;
    if (open_flag && a[AW-1:PW] == open_pg) begin
      exp_lat = we ? 1 + N_WSU + N_WLO : 1 + N_PRD; tag = we ? "R10 page write" : "R6 page read";
    end else if (open_flag) begin
      exp_lat = N_PC + 2 + N_FIRST; tag = "R9 page cross";
    end else begin
      exp_lat = 2 + N_FIRST; tag = "R5 cold access";
    end
    req = 1'b1; req_we = we; req_addr = a; req_be = be; req_wdata = d;
    lat = 0;
    do begin @(negedge clk); lat++; end while (!ack);
    n_ops++;
    chk(lat == exp_lat, tag, lat, exp_lat);
    if (!we) chk(rdata == ref_rd(a), (be == 2'b11) ? "R5 read data" : "R8 read data",
                 int'(rdata), int'(ref_rd(a)));
    else refm[a] = merge(ref_rd(a), be, d);
    req = 1'b0;
    open_flag = 1; open_pg = a[AW-1:PW];
  endtask

  task automatic gap(input int n);
    req = 1'b0;
    repeat (n) @(negedge clk);
    open_flag = 0;
  endtask

  initial begin
    #(CLK_NS * 190000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    req = 0; req_we = 0; req_addr = '0; req_be = 2'b11; req_wdata = '0;
    rst = 1'b1;
    repeat (4) @(negedge clk);
    chk({mem_ce_n, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n, mem_dq_oe, ack} == 7'b1111100,
        "R1 reset outputs", {mem_ce_n, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n, mem_dq_oe, ack},
        7'b1111100);
    rst = 1'b0;
    @(negedge clk);
    chk({mem_ce_n, mem_we_n, mem_dq_oe, ack} == 4'b1100, "R1 after reset",
        {mem_ce_n, mem_we_n, mem_dq_oe, ack}, 4'b1100);
    gap(6);

    // directed
    op(1, 18'h00010, 2'b11, 16'hA5C3);
    op(0, 18'h00010, 2'b11, 16'h0);
    op(1, 18'h00011, 2'b11, 16'hFFFF);
    op(1, 18'h00011, 2'b01, 16'h1234);
    op(1, 18'h00012, 2'b10, 16'h5678);
    op(0, 18'h00011, 2'b11, 16'h0);
    op(0, 18'h00012, 2'b11, 16'h0);
    op(0, 18'h00020, 2'b11, 16'h0);
    req = 1'b0;
    @(negedge clk);
    chk(mem_ce_n == 1'b1, "R12 page closed without request", mem_ce_n, 1);
    gap(8);
    op(1, 18'h3FFFF, 2'b11, 16'hBEEF);
    op(0, 18'h3FFFC, 2'b11, 16'h0);
    op(0, 18'h3FFFF, 2'b11, 16'h0);
    gap(8);
    op(0, 18'h00011, 2'b11, 16'h0);

    // constrained random
    for (int i = 0; i < 250; i++) begin
      logic [AW-1:0] a;
      bit we;
      logic [1:0] be;
      if ($urandom_range(0, 4) == 0) gap(N_PC + 4);
      if (open_flag && $urandom_range(0, 1) == 1) a = {open_pg, 2'($urandom_range(0, 3))};
      else begin
        a = AW'($urandom_range(0, 31));
        if ($urandom_range(0, 3) == 0) a = a ^ 18'h3FFE0;
      end
      we = ($urandom_range(0, 1) == 1);
      be = we ? 2'($urandom_range(1, 3)) : 2'b11;
      op(we, a, be, 16'($urandom));
    end
    gap(4);
    chk(n_acks == n_ops, "R11 one ack per request", n_acks, n_ops);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule